// File: doc/BRIEF.md
# Hex Character Command Assembler

This block sits behind a serial byte receiver and turns a stream of printable characters into a 52-bit command word. Each character in the range 0x30 to 0x3F adds one 4-bit value, taken from the low four bits of the character. So '0' to '9' give 0 to 9, and ':' ';' '<' '=' '>' '?' give A to F. The values go into a shift register. A new value enters at the least significant end, and the oldest value moves toward bit 51. Once more than thirteen values have arrived, the oldest ones drop out at the top.

Two control bytes drive the word. A carriage return (0x0D) finishes the word. It copies the word to the command outputs, raises a one-cycle valid pulse and clears the shift register for the next command. A space (0x20) throws away a partial word. Any other byte has no effect. The finished word appears on three fields: an opcode, a register index and an auxiliary value. These fields keep their value until the next commit.

Top module: `hex_cmd_assembler`

## Requirements
- R1: After reset, `cmd_valid` is 0 and `cmd_opcode`, `cmd_reg` and `cmd_aux` are all 0.
- R2: A byte accepted with `rx_valid` high and value 0x30 to 0x3F adds the nibble `rx_data[3:0]`. For example, ':' (0x3A) adds A and '?' (0x3F) adds F.
- R3: Each nibble shifts in at bits [3:0]. Older nibbles move up by four bits. After more than 13 nibbles, only the 13 most recent remain, with the oldest of them in bits [51:48].
- R4: A byte 0x0D accepted with `rx_valid` high raises `cmd_valid` for exactly one cycle, in the cycle after the byte is accepted. In that cycle the outputs carry the assembled word.
- R5: The output fields split the 52-bit word as follows: `cmd_opcode` = bits [51:48], `cmd_reg` = bits [47:43], `cmd_aux` = bits [42:0].
- R6: A commit clears the shift register. A second 0x0D with no nibbles in between delivers an all-zero word.
- R7: A byte 0x20 accepted with `rx_valid` high clears the shift register and discards any partial word.
- R8: Any other byte value (outside 0x30 to 0x3F, and not 0x0D or 0x20) leaves the shift register unchanged.
- R9: `cmd_opcode`, `cmd_reg` and `cmd_aux` hold their value from one commit to the next, even while new characters arrive.
- R10: A byte presented while `rx_valid` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | High for one cycle for each received byte |
| cmd_valid | output | 1 | One-cycle pulse when a command is committed |
| cmd_opcode | output | 4 | Opcode field of the committed word |
| cmd_reg | output | 5 | Register index field of the committed word |
| cmd_aux | output | 43 | Auxiliary field of the committed word |

## Verification
Each accepted byte changes the internal shift register at the clock edge that samples it. The bench can see that register only through a commit. It therefore follows every character, clear byte or ignored byte with a 0x0D. It then samples at the next falling edge, when `cmd_valid` and the fields reflect the single register stage. One falling edge later, the bench checks that the pulse has ended and that the fields are unchanged. The bench compares against a nibble model it keeps itself, built from R2, R3, R6 and R7. It sweeps all 16 characters, all 256 byte values and overlength words.

// File: rtl/hex_cmd_assembler.sv
module hex_cmd_assembler #(
  parameter int NIBBLES = 13,
  parameter int OP_W = 4,
  parameter int REG_W = 5,
  parameter logic [7:0] COMMIT_CHAR = 8'h0D,
  parameter logic [7:0] CLEAR_CHAR = 8'h20
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [7:0]                        rx_data,
  input  logic                              rx_valid,
  output logic                              cmd_valid,
  output logic [OP_W-1:0]                   cmd_opcode,
  output logic [REG_W-1:0]                  cmd_reg,
  output logic [4*NIBBLES-OP_W-REG_W-1:0]   cmd_aux
);
  localparam int WORD_W = 4 * NIBBLES;

  logic [WORD_W-1:0] shift_q, cmd_q;
  logic              valid_q;

  wire is_hex    = rx_valid && (rx_data[7:4] == 4'h3);
  wire is_commit = rx_valid && (rx_data == COMMIT_CHAR);
  wire is_clear  = rx_valid && (rx_data == CLEAR_CHAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cmd_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= is_commit;
      if (is_commit) begin
        cmd_q   <= shift_q;
        shift_q <= '0;
      end else if (is_clear) begin
        shift_q <= '0;
      end else if (is_hex) begin
        shift_q <= {shift_q[WORD_W-5:0], rx_data[3:0]};
      end
    end
  end

  assign cmd_valid  = valid_q;
  assign cmd_opcode = cmd_q[WORD_W-1 -: OP_W];
  assign cmd_reg    = cmd_q[WORD_W-OP_W-1 -: REG_W];
  assign cmd_aux    = cmd_q[WORD_W-OP_W-REG_W-1:0];
endmodule

// File: rtl/hex_cmd_assembler_chk.sv
module hex_cmd_assembler_chk #(
  parameter int NIBBLES = 13,
  parameter int OP_W = 4,
  parameter int REG_W = 5,
  parameter logic [7:0] COMMIT_CHAR = 8'h0D,
  parameter logic [7:0] CLEAR_CHAR = 8'h20
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [7:0]                      rx_data,
  input logic                            rx_valid,
  input logic                            cmd_valid,
  input logic [OP_W-1:0]                 cmd_opcode,
  input logic [REG_W-1:0]                cmd_reg,
  input logic [4*NIBBLES-OP_W-REG_W-1:0] cmd_aux,
  input logic [4*NIBBLES-1:0]            shift_q
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else armed <= 1'b1;

  wire commit_in = rx_valid && (rx_data == COMMIT_CHAR);
  wire clear_in  = rx_valid && (rx_data == CLEAR_CHAR);
  wire hex_in    = rx_valid && (rx_data[7:4] == 4'h3);
  wire other_in  = rx_valid && !hex_in && !commit_in && !clear_in;

  AST_VALID_FOLLOWS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(commit_in) |-> cmd_valid); // R4
  AST_VALID_ONLY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    cmd_valid |-> $past(commit_in)); // R4
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !cmd_valid |-> $stable({cmd_opcode, cmd_reg, cmd_aux})); // R9
  AST_EMPTY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(commit_in) |-> (shift_q == '0)); // R6
  AST_EMPTY_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(clear_in) |-> (shift_q == '0)); // R7
  AST_OTHER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(other_in) |-> $stable(shift_q)); // R8
  AST_IDLE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(!rx_valid) |-> $stable(shift_q)); // R10
  AST_NIBBLE_ENTERS_LOW: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    $past(hex_in) |-> (shift_q[3:0] == $past(rx_data[3:0]))); // R2
endmodule

bind hex_cmd_assembler hex_cmd_assembler_chk #(
  .NIBBLES(NIBBLES), .OP_W(OP_W), .REG_W(REG_W),
  .COMMIT_CHAR(COMMIT_CHAR), .CLEAR_CHAR(CLEAR_CHAR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
  .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_reg(cmd_reg),
  .cmd_aux(cmd_aux), .shift_q(shift_q)
);

// File: tb/hex_cmd_assembler_tb.sv
module hex_cmd_assembler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        rx_valid = 1'b0;
  logic        cmd_valid;
  logic [3:0]  cmd_opcode;
  logic [4:0]  cmd_reg;
  logic [42:0] cmd_aux;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [51:0] model = '0;

  always #10 clk = ~clk;

  hex_cmd_assembler u_dut (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_valid(rx_valid),
    .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode), .cmd_reg(cmd_reg),
    .cmd_aux(cmd_aux)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_data = b;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    if (b[7:4] == 4'h3) model = {model[47:0], b[3:0]};
    else if (b == 8'h20) model = '0;
  endtask

  task automatic commit(input string req);
    logic [51:0] word;
    @(negedge clk);
    rx_data = 8'h0D;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    word = {cmd_opcode, cmd_reg, cmd_aux};
    chk({req, " R4 pulse"}, 64'(cmd_valid), 64'd1);
    chk({req, " word"}, 64'(word), 64'(model));
    chk("R5 opcode", 64'(cmd_opcode), 64'(model[51:48]));
    chk("R5 reg", 64'(cmd_reg), 64'(model[47:43]));
    chk("R5 aux", 64'(cmd_aux), 64'(model[42:0]));
    model = '0;
    @(negedge clk);
    chk("R4 single cycle", 64'(cmd_valid), 64'd0);
    chk("R9 hold after pulse", 64'({cmd_opcode, cmd_reg, cmd_aux}), 64'(word));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", 64'(cmd_valid), 64'd0);
    chk("R1 fields", 64'({cmd_opcode, cmd_reg, cmd_aux}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", 64'(cmd_valid), 64'd0);

    // R2/R3: every character, fully packed word
    for (int v = 0; v < 16; v++) begin
      for (int k = 0; k < 13; k++) send(8'h30 + 8'((v + k) % 16));
      commit("R2");
    end

    // R3: overlength words keep the newest 13 nibbles
    for (int len = 1; len <= 20; len++) begin
      for (int k = 0; k < len; k++) send(8'h30 + 8'((k * 7 + len) % 16));
      commit("R3");
    end

    // R6: back-to-back commit gives zero
    send(8'h3F); send(8'h3A);
    commit("R6 first");
    commit("R6 second");

    // R7: clear discards partial word
    for (int k = 0; k < 9; k++) send(8'h35);
    send(8'h20);
    send(8'h31); send(8'h3C);
    commit("R7");

    // R8: every other byte value is ignored
    for (int b = 0; b < 256; b++) begin
      if (b[7:4] != 4'h3 && b != 8'h0D && b != 8'h20) begin
        send(8'h39); send(8'h3E); send(8'h32);
        send(8'(b));
        send(8'h37);
        commit("R8");
      end
    end

    // R9: fields stable while characters stream in
    for (int k = 0; k < 13; k++) send(8'h3B);
    commit("R9 load");
    for (int k = 0; k < 6; k++) begin
      send(8'h34);
      chk("R9 stable", 64'({cmd_opcode, cmd_reg, cmd_aux}), 64'h000B_BBBB_BBBB_BBBB);
      chk("R9 no pulse", 64'(cmd_valid), 64'd0);
    end
    commit("R9 next");

    // R10: bytes with rx_valid low have no effect
    send(8'h36);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      rx_data = (k % 2 == 0) ? 8'h0D : 8'h3A;
    end
    @(negedge clk);
    chk("R10 no pulse", 64'(cmd_valid), 64'd0);
    rx_data = 8'h20;
    @(negedge clk);
    commit("R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule